// File: doc/BRIEF.md
# Interval Timer Host Register Interface

This block is the host-facing register front end for a three-channel 16-bit interval timer. A host reaches it over an 8-bit data bus using an active-low chip select, active-low read and write strobes and a two-bit address. Each strobe is sampled on the system clock, and every cycle in which it is low counts as one access. Address values 0 to 2 select the data ports of the three channels. Address 3 selects a write-only control port.

A control byte names the channel it targets, so channels can be programmed in any order. The control byte either sets the channel's access width and waveform mode, or freezes the channel's count into an output latch. Initial counts are assembled in a per-channel count register and handed to the counting element through a one-cycle load strobe. Read-back comes from the live count, or from the frozen snapshot while a latch is pending.

The block keeps separate write and read byte pointers per channel, which survive accesses to other channels. It also keeps a per-channel flag that shows whether a freshly written count is still waiting to be taken by the counting element. The counting element and the waveform generation sit outside this block. They see only the count register, its load strobe, a control strobe and the mode field, and they return the live count and a load acknowledge.

Top module: `tmr_regif`

## Requirements
- R1: While `cs_n` is high, reads and writes have no effect: no strobe is raised, no mode or count register changes, and `dout_oe` stays low.
- R2: A write to address 3 is a control byte with select in bits [7:6] (0 to 2 name a channel, 3 is ignored), access code in bits [5:4] and mode in bits [3:1]; bit 0 is ignored. A non-latch control byte updates only the named channel's mode and pulses only that channel's `ch_ctrl_stb` for the cycle after the write.
- R3: With access code 01 (low byte only) a data write loads the count register with {8'h00, data}. With code 10 (high byte only) it loads {data, 8'h00}. In both cases the channel's `ch_cr_stb` pulses in the following cycle.
- R4: With access code 11 the first data write fills the low byte without a strobe, and the second fills the high byte and pulses `ch_cr_stb`. Reads and accesses to other channels between the two writes do not disturb this order.
- R5: A channel read returns the low byte for code 01 and the high byte for code 10. For code 11 it returns the low byte, then the high byte on the next read of that channel. The read pointer is independent of the write pointer.
- R6: A control byte with access code 00 freezes the named channel's present count. Reads return the frozen value until a full read sequence (one byte, or two for code 11) completes, and after that reads follow the live count again.
- R7: A latch command to a channel whose frozen value has not yet been fully read is ignored.
- R8: `ch_null` is set by a non-latch control byte to that channel and by a completed count write. It is cleared by `ch_load` for that channel. A set in the same cycle as a clear wins.
- R9: A read of address 3 leaves `dout_oe` low and `dout` at zero.
- R10: After reset every channel uses access code 01 and mode 0, with a zero count register, a clear null flag and no latch. A non-latch control byte resets the named channel's byte pointers and discards its pending latch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| rd_n | input | 1 | Active-low read strobe |
| wr_n | input | 1 | Active-low write strobe |
| addr | input | 2 | Port address: 0-2 channel data, 3 control |
| din | input | 8 | Write data |
| dout | output | 8 | Read data, zero when not driven |
| dout_oe | output | 1 | High while `dout` carries valid read data |
| ch_count | input | 48 | Live count of each channel, channel i at [16i+15:16i] |
| ch_load | input | 3 | Per channel: the counting element took the count register |
| ch_cr | output | 48 | Count register of each channel |
| ch_cr_stb | output | 3 | Per channel: one-cycle pulse when a new count is complete |
| ch_ctrl_stb | output | 3 | Per channel: one-cycle pulse after a control byte, resets that counter's logic |
| ch_mode | output | 9 | Mode field of each channel, channel i at [3i+2:3i] |
| ch_null | output | 3 | Per channel: new count not yet loaded |

## Verification
The hardest state to reach from the ports is a half-consumed two-byte sequence that is then mixed with other traffic. Examples are a latch command issued after the low byte of a live read, or a second latch command while a snapshot is half read. The stimulus reaches these by programming two-byte access and then inserting, between the two bytes, reads of the same channel, writes to the control port and changes of the live count. Each byte returned is compared against the snapshot or live value the bench predicts at that point.

// File: rtl/tmr_pkg.sv
// Shared types for the timer host register interface.
// Assumes the 8-bit control byte layout given in the requirements.
package tmr_pkg;
    typedef enum logic [1:0] {
        ACC_LATCH = 2'b00,
        ACC_LO    = 2'b01,
        ACC_HI    = 2'b10,
        ACC_BOTH  = 2'b11
    } acc_e;
endpackage

// File: rtl/tmr_host_decode.sv
// Host strobe decoder: turns chip select, strobes, address and the control
// byte's select/access fields into per-channel one-cycle access requests.
// Assumes at most three channels, because the select field is two bits wide.
module tmr_host_decode
    import tmr_pkg::*;
#(
    parameter int NCH = 3,
    parameter int AW  = 2
) (
    input  logic           cs_n,
    input  logic           rd_n,
    input  logic           wr_n,
    input  logic [AW-1:0]  addr,
    input  logic [1:0]     cw_sel,
    input  logic [1:0]     cw_acc,
    output logic [NCH-1:0] data_wr,
    output logic [NCH-1:0] data_rd,
    output logic [NCH-1:0] ctrl_hit,
    output logic [NCH-1:0] latch_hit
);
    localparam logic [AW-1:0] CTRL_ADDR = AW'(NCH);

    logic wr_act, rd_act, ctl_wr;

    // qualify strobes by chip select
    always_comb begin
        wr_act = !cs_n && !wr_n;
        rd_act = !cs_n && !rd_n;
        ctl_wr = wr_act && (addr == CTRL_ADDR);
    end

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_dec
            // per-channel request decode
            always_comb begin
                data_wr[i]   = wr_act && (addr == AW'(i));
                data_rd[i]   = rd_act && (addr == AW'(i));
                ctrl_hit[i]  = ctl_wr && (cw_sel == 2'(i)) && (acc_e'(cw_acc) != ACC_LATCH);
                latch_hit[i] = ctl_wr && (cw_sel == 2'(i)) && (acc_e'(cw_acc) == ACC_LATCH);
            end
        end
    endgenerate
endmodule

// File: rtl/tmr_chan_regs.sv
// Per-channel register set: access width, mode, count register with write
// byte pointer, read byte pointer, output latch and null-count flag.
// Assumes that at most one of data_wr, ctrl_hit, latch_hit is active per cycle.
module tmr_chan_regs
    import tmr_pkg::*;
#(
    parameter int DW = 8,
    parameter int CW = 2 * DW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          ctrl_hit,
    input  logic          latch_hit,
    input  logic [DW-1:0] din,
    input  logic [CW-1:0] live,
    input  logic          load_ack,
    output logic [DW-1:0] rd_byte,
    output logic [CW-1:0] cr,
    output logic          cr_stb,
    output logic          ctrl_stb,
    output logic [2:0]    mode,
    output logic          null_cnt
);
    acc_e          acc_q;
    logic [2:0]    mode_q;
    logic          wr_ptr, rd_ptr, lat_q;
    logic [CW-1:0] ol_q, cr_q, src;
    logic          cr_stb_q, ctrl_stb_q, null_q;
    logic          wr_done, rd_last;

    // completion of a count write and of a read sequence
    always_comb begin
        wr_done = data_wr && ((acc_q != ACC_BOTH) || wr_ptr);
        rd_last = (acc_q != ACC_BOTH) || rd_ptr;
    end

    // access width and mode from a non-latch control byte
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= ACC_LO;
            mode_q <= 3'd0;
        end else if (ctrl_hit) begin
            acc_q  <= acc_e'(din[5:4]);
            mode_q <= din[3:1];
        end
    end

    // count register assembly and write byte pointer
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_q   <= '0;
            wr_ptr <= 1'b0;
        end else if (ctrl_hit) begin
            wr_ptr <= 1'b0;
        end else if (data_wr) begin
            case (acc_q)
                ACC_HI:   cr_q <= {din, {DW{1'b0}}};
                ACC_BOTH: begin
                    if (wr_ptr) cr_q[CW-1:DW] <= din;
                    else        cr_q[DW-1:0]  <= din;
                    wr_ptr <= !wr_ptr;
                end
                default:  cr_q <= {{DW{1'b0}}, din};
            endcase
        end
    end

    // one-cycle strobes towards the counting element
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cr_stb_q   <= 1'b0;
            ctrl_stb_q <= 1'b0;
        end else begin
            cr_stb_q   <= wr_done;
            ctrl_stb_q <= ctrl_hit;
        end
    end

    // null-count flag: set beats clear
    always_ff @(posedge clk) begin
        if (!rst_n)                   null_q <= 1'b0;
        else if (ctrl_hit || wr_done) null_q <= 1'b1;
        else if (load_ack)            null_q <= 1'b0;
    end

    // read byte pointer
    always_ff @(posedge clk) begin
        if (!rst_n)                            rd_ptr <= 1'b0;
        else if (ctrl_hit)                     rd_ptr <= 1'b0;
        else if (data_rd && acc_q == ACC_BOTH) rd_ptr <= !rd_ptr;
    end

    // output latch: freeze on command, release after a full read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_q <= 1'b0;
            ol_q  <= '0;
        end else if (ctrl_hit) begin
            lat_q <= 1'b0;
        end else if (latch_hit && !lat_q) begin
            lat_q <= 1'b1;
            ol_q  <= live;
        end else if (data_rd && lat_q && rd_last) begin
            lat_q <= 1'b0;
        end
    end

    // read byte selection
    always_comb begin
        src = lat_q ? ol_q : live;
        case (acc_q)
            ACC_HI:   rd_byte = src[CW-1:DW];
            ACC_BOTH: rd_byte = rd_ptr ? src[CW-1:DW] : src[DW-1:0];
            default:  rd_byte = src[DW-1:0];
        endcase
    end

    assign cr       = cr_q;
    assign cr_stb   = cr_stb_q;
    assign ctrl_stb = ctrl_stb_q;
    assign mode     = mode_q;
    assign null_cnt = null_q;

    AST_CTRL_SETS_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_hit |=> null_cnt); // R8
    AST_LOAD_CLEARS_NULL: assert property (@(posedge clk) disable iff (!rst_n)
        (load_ack && !ctrl_hit && !data_wr) |=> !null_cnt); // R8
    AST_LO_HIGH_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cr_stb && acc_q == ACC_LO) |-> (cr[CW-1:DW] == '0)); // R3
    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && !data_rd && !ctrl_hit) |=> (lat_q && $stable(ol_q))); // R6
    AST_SECOND_LATCH_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_q && latch_hit) |=> $stable(ol_q)); // R7
endmodule

// File: rtl/tmr_regif.sv
// Top of the timer host register interface: strobe decode, one register set
// per channel, and the read-data multiplexer.
// Assumes host strobes are synchronous to clk; each low cycle is one access.
module tmr_regif #(
    parameter int NCH = 3,
    parameter int DW  = 8,
    parameter int CW  = 2 * DW,
    parameter int AW  = $clog2(NCH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    din,
    output logic [DW-1:0]    dout,
    output logic             dout_oe,
    input  logic [NCH*CW-1:0] ch_count,
    input  logic [NCH-1:0]   ch_load,
    output logic [NCH*CW-1:0] ch_cr,
    output logic [NCH-1:0]   ch_cr_stb,
    output logic [NCH-1:0]   ch_ctrl_stb,
    output logic [NCH*3-1:0] ch_mode,
    output logic [NCH-1:0]   ch_null
);
    logic [NCH-1:0]    data_wr, data_rd, ctrl_hit, latch_hit;
    logic [NCH*DW-1:0] rd_bytes;

    tmr_host_decode #(.NCH(NCH), .AW(AW)) u_dec (
        .cs_n      (cs_n),
        .rd_n      (rd_n),
        .wr_n      (wr_n),
        .addr      (addr),
        .cw_sel    (din[7:6]),
        .cw_acc    (din[5:4]),
        .data_wr   (data_wr),
        .data_rd   (data_rd),
        .ctrl_hit  (ctrl_hit),
        .latch_hit (latch_hit)
    );

    genvar i;
    generate
        for (i = 0; i < NCH; i++) begin : g_ch
            tmr_chan_regs #(.DW(DW), .CW(CW)) u_ch (
                .clk       (clk),
                .rst_n     (rst_n),
                .data_wr   (data_wr[i]),
                .data_rd   (data_rd[i]),
                .ctrl_hit  (ctrl_hit[i]),
                .latch_hit (latch_hit[i]),
                .din       (din),
                .live      (ch_count[i*CW +: CW]),
                .load_ack  (ch_load[i]),
                .rd_byte   (rd_bytes[i*DW +: DW]),
                .cr        (ch_cr[i*CW +: CW]),
                .cr_stb    (ch_cr_stb[i]),
                .ctrl_stb  (ch_ctrl_stb[i]),
                .mode      (ch_mode[i*3 +: 3]),
                .null_cnt  (ch_null[i])
            );
        end
    endgenerate

    // read-data mux: only a selected channel port drives the bus
    always_comb begin
        dout    = '0;
        dout_oe = |data_rd;
        for (int k = 0; k < NCH; k++) begin
            if (data_rd[k]) dout = dout | rd_bytes[k*DW +: DW];
        end
    end

    AST_DESELECT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |=> (ch_cr_stb == '0 && ch_ctrl_stb == '0)); // R1
    AST_ONE_CTRL_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(ch_ctrl_stb)); // R2
    AST_CTRL_PORT_UNDRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !rd_n && addr == AW'(NCH)) |-> (!dout_oe && dout == '0)); // R9
endmodule

// File: tb/sim_tmr_regif.sv
module sim_tmr_regif;
    localparam int P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1;
    logic [1:0]  addr = 2'd0;
    logic [7:0]  din = 8'd0;
    logic [7:0]  dout;
    logic        dout_oe;
    logic [47:0] ch_count = '0;
    logic [2:0]  ch_load = '0;
    logic [47:0] ch_cr;
    logic [2:0]  ch_cr_stb, ch_ctrl_stb, ch_null;
    logic [8:0]  ch_mode;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [7:0] rb;
    logic       roe;

    tmr_regif u0 (.*);

    always #(P/2) clk = !clk;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk); cs_n = 0; wr_n = 0; addr = a; din = d;
        @(negedge clk); cs_n = 1; wr_n = 1;
    endtask

    task automatic rd(input logic [1:0] a);
        @(negedge clk); cs_n = 0; rd_n = 0; addr = a;
        #(P/4); rb = dout; roe = dout_oe;
        @(negedge clk); cs_n = 1; rd_n = 1;
    endtask

    task automatic ld(input int ch);
        @(negedge clk); ch_load[ch] = 1'b1;
        @(negedge clk); ch_load = '0;
    endtask

    function automatic logic [7:0] cw(input int sel, input int acc, input int m);
        return {2'(sel), 2'(acc), 3'(m), 1'b0};
    endfunction

    function automatic logic [15:0] crof(input int ch);
        return ch_cr[ch*16 +: 16];
    endfunction

    initial begin
        #(P*100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        // R10 reset state
        chk("R10 null", ch_null, 0);
        chk("R10 cr", ch_cr[31:0], 0);
        chk("R10 mode", ch_mode, 0);
        chk("R10 oe", dout_oe, 0);

        // R1 deselected accesses ignored
        @(negedge clk); cs_n = 1; wr_n = 0; addr = 3; din = cw(1, 3, 5);
        @(negedge clk); chk("R1 ctrl stb", ch_ctrl_stb, 0);
        addr = 0; din = 8'h77;
        @(negedge clk); wr_n = 1; rd_n = 0;
        chk("R1 cr stb", ch_cr_stb, 0);
        chk("R1 mode", ch_mode, 0);
        chk("R1 null", ch_null, 0);
        chk("R1 oe", dout_oe, 0);
        @(negedge clk); rd_n = 1;
        chk("R1 cr", crof(0), 0);

        // R2 R3 R4 R8 sweep over channels and write widths
        for (int ch = 0; ch < 3; ch++) begin
            for (int acc = 1; acc < 4; acc++) begin
                logic [15:0] v;
                int m;
                m = (ch * 3 + acc) % 6;
                v = 16'h1234 + 16'(ch) * 16'h1111 + 16'(acc) * 16'h0f01;
                wr(3, cw(ch, acc, m));
                chk("R2 ctrl stb", ch_ctrl_stb, 32'(1 << ch));
                chk("R2 mode", ch_mode[ch*3 +: 3], m);
                chk("R8 null set by ctrl", ch_null[ch], 1);
                ld(ch);
                chk("R8 null cleared by load", ch_null[ch], 0);
                if (acc == 1) begin
                    wr(2'(ch), v[7:0]);
                    chk("R3 lo stb", ch_cr_stb, 32'(1 << ch));
                    chk("R3 lo value", crof(ch), {8'h00, v[7:0]});
                end else if (acc == 2) begin
                    wr(2'(ch), v[15:8]);
                    chk("R3 hi stb", ch_cr_stb, 32'(1 << ch));
                    chk("R3 hi value", crof(ch), {v[15:8], 8'h00});
                end else begin
                    wr(2'(ch), v[7:0]);
                    chk("R4 no stb after first", ch_cr_stb, 0);
                    rd(2'((ch + 1) % 3));
                    rd(2'(ch));
                    wr(2'((ch + 2) % 3 == ch ? 0 : 3), cw(3, 3, 0));
                    wr(2'(ch), v[15:8]);
                    chk("R4 stb after second", ch_cr_stb, 32'(1 << ch));
                    chk("R4 value", crof(ch), v);
                end
                chk("R8 null after count", ch_null[ch], 1);
                @(negedge clk);
                chk("R3 stb one cycle", ch_cr_stb, 0);
            end
        end

        // R8 set wins over clear
        @(negedge clk); cs_n = 0; wr_n = 0; addr = 3; din = cw(0, 1, 0); ch_load = 3'b001;
        @(negedge clk); cs_n = 1; wr_n = 1; ch_load = '0;
        chk("R8 set beats clear", ch_null[0], 1);

        // R5 reads following the live count
        for (int ch = 0; ch < 3; ch++) begin
            for (int acc = 1; acc < 4; acc++) begin
                logic [15:0] a, b;
                a = 16'hA05C ^ 16'(ch * 257 + acc * 17);
                b = a + 16'h3311;
                wr(3, cw(ch, acc, 2));
                ch_count[ch*16 +: 16] = a;
                rd(2'(ch));
                chk("R5 oe", roe, 1);
                if (acc == 2) chk("R5 hi only", rb, a[15:8]);
                else          chk("R5 low byte", rb, a[7:0]);
                if (acc == 3) begin
                    wr(2'(ch), 8'h5A);
                    ch_count[ch*16 +: 16] = b;
                    rd(2'(ch));
                    chk("R5 high byte follows live", rb, b[15:8]);
                    rd(2'(ch));
                    chk("R5 pointer wraps", rb, b[7:0]);
                    wr(2'(ch), 8'hC3);
                    chk("R5 write ptr independent", crof(ch), 16'hC35A);
                end
            end
        end

        // R6 R7 latch on channel 1, two-byte access
        wr(3, cw(1, 3, 0));
        ch_count[16 +: 16] = 16'hBEEF;
        wr(3, cw(1, 0, 0));
        ch_count[16 +: 16] = 16'h1357;
        rd(1);
        chk("R6 latched low", rb, 8'hEF);
        ch_count[16 +: 16] = 16'h2468;
        wr(3, cw(1, 0, 0));
        rd(1);
        chk("R7 latched high kept", rb, 8'hBE);
        rd(1);
        chk("R6 released low", rb, 8'h68);
        rd(1);
        chk("R6 released high", rb, 8'h24);

        // R6 latch on channel 2, high byte only
        wr(3, cw(2, 2, 0));
        ch_count[32 +: 16] = 16'h9ABC;
        wr(3, cw(2, 0, 0));
        ch_count[32 +: 16] = 16'h1111;
        rd(2);
        chk("R6 single latched", rb, 8'h9A);
        rd(2);
        chk("R6 single released", rb, 8'h11);

        // R9 control port not readable
        rd(3);
        chk("R9 oe", roe, 0);
        chk("R9 data", rb, 0);

        // R10 control byte resets pointers and latch
        wr(3, cw(0, 3, 0));
        wr(0, 8'h11);
        wr(3, cw(0, 3, 0));
        wr(0, 8'h22);
        wr(0, 8'h33);
        chk("R10 write ptr reset", crof(0), 16'h3322);
        ch_count[15:0] = 16'h4455;
        rd(0);
        wr(3, cw(0, 0, 0));
        ch_count[15:0] = 16'h6677;
        wr(3, cw(0, 3, 0));
        rd(0);
        chk("R10 read ptr and latch reset", rb, 8'h77);

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule